// File: doc/BRIEF.md
# Netlist Text Line Formatter

This block converts circuit component records into one line of text each, in the style of a SPICE netlist. It sends the lines out as ASCII bytes. A record gives a component class (DC voltage source, resistor or NPN transistor), an instance number, up to three node numbers, and a value with a multiplier code. The block prints the numbers in decimal, puts one space between fields, adds the keyword, suffix or model name that goes with the class, and ends every line with carriage return and line feed.

Records come in one at a time through a valid/ready pair. The block takes a new record only when it is idle. Bytes leave through a second valid/ready pair, so the block can feed a serial transmitter or a character display at any rate. While the sink holds ready low, the block holds its current byte and its position in the line. A done flag shows that the last record of a list has been fully written out.

Top module: `netlist_line_fmt`

## Requirements
- R1: After reset, rec_ready is 1, out_valid is 0 and done is 0.
- R2: A class 0 record (voltage source) produces `V <index> <node_a> <node_b> DC <value>`.
- R3: A class 1 record (resistor) produces `R <index> <node_a> <node_b> <value>`, and a multiplier letter follows the value with no space. Multiplier code 0 adds no letter, 1 adds `k`, 2 adds `m` and 3 adds `u`.
- R4: A class 2 record (NPN transistor) produces `Q <index> <collector> <base> <emitter> NPN`. The collector, base and emitter come from node_a, node_b and node_c, in that order.
- R5: Fields are separated by exactly one space (0x20), with a space between the class letter and the index. Every line ends with 0x0D followed by 0x0A.
- R6: Index, node and value fields from 0 to 999 are printed in decimal without leading zeros. A zero field prints as the single character `0`.
- R7: A record with class code 3 is accepted but produces no bytes. The block is then ready for the next record.
- R8: A byte is transferred when out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, out_valid and out_byte hold their values. With out_ready held at 1, the bytes of a line leave on consecutive cycles.
- R9: rec_ready is 1 only while no line is being sent. A record is taken on a cycle where rec_valid and rec_ready are both 1.
- R10: done goes to 1 after the final byte of a record marked rec_last has been sent, or once a class 3 record marked rec_last has been taken. done returns to 0 when the next record is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Block is idle and takes a record |
| rec_last | input | 1 | Record is the last of the list |
| rec_class | input | 2 | 0 source, 1 resistor, 2 NPN, 3 skip |
| rec_index | input | NUM_W | Instance number |
| rec_node_a | input | NUM_W | First node (collector for NPN) |
| rec_node_b | input | NUM_W | Second node (base for NPN) |
| rec_node_c | input | NUM_W | Emitter node, NPN only |
| rec_value | input | NUM_W | Numeric value (source, resistor) |
| rec_mult | input | 2 | Resistor multiplier code |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Sink takes the byte |
| out_byte | output | 8 | ASCII character |
| done | output | 1 | Last record fully emitted |

## Verification
The bench checks the edges of the decimal conversion: zero fields, one-, two- and three-digit fields, and fields such as 100 and 305 that have zeros inside or at the end. A converter that drops those zeros, or that prints a zero field as nothing, would produce lines of the wrong length. The bench also stalls the sink on regular and on sparse patterns. If a design advanced its position in the line while ready was low, bytes would go missing or repeat. It sends a resistor with no multiplier to confirm that the block adds no stray character and leaves no idle cycle. It sends skipped records, including one marked last: if the design emitted bytes for an unknown class, or never raised done for a skipped last record, the list would never be seen to end.

// File: rtl/netfmt_pkg.sv
package netfmt_pkg;

    localparam int STEP_W = 5;

    localparam logic [7:0] CH_SP = 8'h20;
    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_V  = 8'h56;
    localparam logic [7:0] CH_R  = 8'h52;
    localparam logic [7:0] CH_Q  = 8'h51;
    localparam logic [7:0] CH_D  = 8'h44;
    localparam logic [7:0] CH_C  = 8'h43;
    localparam logic [7:0] CH_N  = 8'h4E;
    localparam logic [7:0] CH_P  = 8'h50;
    localparam logic [7:0] CH_0  = 8'h30;

    typedef enum logic [1:0] {
        CLS_VSRC = 2'd0,
        CLS_RES  = 2'd1,
        CLS_NPN  = 2'd2,
        CLS_SKIP = 2'd3
    } comp_cls_e;

    typedef enum logic [1:0] {
        TK_LIT = 2'd0,
        TK_NUM = 2'd1,
        TK_SFX = 2'd2,
        TK_END = 2'd3
    } tok_kind_e;

    typedef enum logic [2:0] {
        FLD_IDX = 3'd0,
        FLD_NA  = 3'd1,
        FLD_NB  = 3'd2,
        FLD_NC  = 3'd3,
        FLD_VAL = 3'd4
    } fld_sel_e;

    typedef struct packed {
        tok_kind_e  kind;
        logic [7:0] ch;
        fld_sel_e   fld;
    } tok_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fmt_state_e;

    function automatic logic [7:0] mult_char(logic [1:0] code);
        case (code)
            2'd1:    return 8'h6B;
            2'd2:    return 8'h6D;
            2'd3:    return 8'h75;
            default: return CH_SP;
        endcase
    endfunction

endpackage

// File: rtl/netfmt_bcd.sv
module netfmt_bcd #(
    parameter  int NUM_W  = 10,
    parameter  int DIGITS = 3,
    localparam int CNT_W  = $clog2(DIGITS + 1)
) (
    input  logic [NUM_W-1:0]    bin,
    output logic [DIGITS*4-1:0] bcd,
    output logic [CNT_W-1:0]    ndig
);

    logic [DIGITS-1:0] nz;

    always_comb begin
        logic [DIGITS*4-1:0] acc;
        acc = '0;
        for (int i = NUM_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (acc[d*4+:4] > 4'd4) begin
                    acc[d*4+:4] = acc[d*4+:4] + 4'd3;
                end
            end
            acc = {acc[DIGITS*4-2:0], bin[i]};
        end
        bcd = acc;
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_nz
        assign nz[g] = |bcd[g*4+:4];
    end

    always_comb begin
        ndig = CNT_W'(1);
        for (int d = 1; d < DIGITS; d++) begin
            if (nz[d]) begin
                ndig = CNT_W'(d + 1);
            end
        end
    end

endmodule

// File: rtl/netfmt_tokens.sv
module netfmt_tokens
    import netfmt_pkg::*;
(
    input  comp_cls_e         cls,
    input  logic              has_sfx,
    input  logic [STEP_W-1:0] step,
    output tok_t              tok
);

    function automatic tok_t t_lit(logic [7:0] c);
        return '{kind: TK_LIT, ch: c, fld: FLD_IDX};
    endfunction

    function automatic tok_t t_num(fld_sel_e f);
        return '{kind: TK_NUM, ch: CH_0, fld: f};
    endfunction

    function automatic tok_t t_sfx();
        return '{kind: TK_SFX, ch: CH_SP, fld: FLD_IDX};
    endfunction

    function automatic tok_t t_end();
        return '{kind: TK_END, ch: CH_SP, fld: FLD_IDX};
    endfunction

    logic [7:0] lead;
    tok_t       tail;
    int         ts;

    always_comb begin
        case (cls)
            CLS_VSRC: lead = CH_V;
            CLS_RES:  lead = CH_R;
            default:  lead = CH_Q;
        endcase
    end

    always_comb begin
        ts   = int'(step) - 8;
        tail = t_end();
        case (cls)
            CLS_VSRC: begin
                case (ts)
                    0: tail = t_lit(CH_D);
                    1: tail = t_lit(CH_C);
                    2: tail = t_lit(CH_SP);
                    3: tail = t_num(FLD_VAL);
                    4: tail = t_lit(CH_CR);
                    5: tail = t_lit(CH_LF);
                    default: tail = t_end();
                endcase
            end
            CLS_RES: begin
                if (has_sfx) begin
                    case (ts)
                        0: tail = t_num(FLD_VAL);
                        1: tail = t_sfx();
                        2: tail = t_lit(CH_CR);
                        3: tail = t_lit(CH_LF);
                        default: tail = t_end();
                    endcase
                end else begin
                    case (ts)
                        0: tail = t_num(FLD_VAL);
                        1: tail = t_lit(CH_CR);
                        2: tail = t_lit(CH_LF);
                        default: tail = t_end();
                    endcase
                end
            end
            CLS_NPN: begin
                case (ts)
                    0: tail = t_num(FLD_NC);
                    1: tail = t_lit(CH_SP);
                    2: tail = t_lit(CH_N);
                    3: tail = t_lit(CH_P);
                    4: tail = t_lit(CH_N);
                    5: tail = t_lit(CH_CR);
                    6: tail = t_lit(CH_LF);
                    default: tail = t_end();
                endcase
            end
            default: tail = t_end();
        endcase
    end

    always_comb begin
        tok = t_end();
        if (cls != CLS_SKIP) begin
            case (int'(step))
                0:          tok = t_lit(lead);
                1, 3, 5, 7: tok = t_lit(CH_SP);
                2:          tok = t_num(FLD_IDX);
                4:          tok = t_num(FLD_NA);
                6:          tok = t_num(FLD_NB);
                default:    tok = tail;
            endcase
        end
    end

endmodule

// File: rtl/netlist_line_fmt.sv
module netlist_line_fmt
    import netfmt_pkg::*;
#(
    parameter int NUM_W  = 10,
    parameter int DIGITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    output logic             rec_ready,
    input  logic             rec_last,
    input  logic [1:0]       rec_class,
    input  logic [NUM_W-1:0] rec_index,
    input  logic [NUM_W-1:0] rec_node_a,
    input  logic [NUM_W-1:0] rec_node_b,
    input  logic [NUM_W-1:0] rec_node_c,
    input  logic [NUM_W-1:0] rec_value,
    input  logic [1:0]       rec_mult,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             done
);

    localparam int CNT_W = $clog2(DIGITS + 1);
    localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam int BCD_W = DIGITS * 4;

    typedef struct packed {
        fmt_state_e        st;
        logic [STEP_W-1:0] step;
        logic              num_act;
        logic [IDX_W-1:0]  dig;
        logic              done;
        logic              last;
        comp_cls_e         cls;
        logic [1:0]        mult;
        logic [NUM_W-1:0]  idx;
        logic [NUM_W-1:0]  na;
        logic [NUM_W-1:0]  nb;
        logic [NUM_W-1:0]  nc;
        logic [NUM_W-1:0]  val;
    } fmt_reg_t;

    fmt_reg_t s_d, s_q;

    tok_t             tok;
    logic [NUM_W-1:0] fval;
    logic [BCD_W-1:0] fbcd;
    logic [CNT_W-1:0] fndig;
    logic [IDX_W-1:0] cur_di;
    logic [3:0]       dsel;
    logic             has_byte;
    logic [7:0]       byte_d;
    logic             fire;

    netfmt_tokens u_tokens (
        .cls     (s_q.cls),
        .has_sfx (s_q.mult != 2'd0),
        .step    (s_q.step),
        .tok     (tok)
    );

    always_comb begin
        case (tok.fld)
            FLD_IDX: fval = s_q.idx;
            FLD_NA:  fval = s_q.na;
            FLD_NB:  fval = s_q.nb;
            FLD_NC:  fval = s_q.nc;
            default: fval = s_q.val;
        endcase
    end

    netfmt_bcd #(
        .NUM_W  (NUM_W),
        .DIGITS (DIGITS)
    ) u_bcd (
        .bin  (fval),
        .bcd  (fbcd),
        .ndig (fndig)
    );

    assign cur_di = s_q.num_act ? s_q.dig : IDX_W'(fndig - CNT_W'(1));
    assign dsel   = 4'(fbcd >> (int'(cur_di) * 4));

    always_comb begin
        case (tok.kind)
            TK_LIT:  begin has_byte = 1'b1; byte_d = tok.ch; end
            TK_NUM:  begin has_byte = 1'b1; byte_d = CH_0 | {4'h0, dsel}; end
            TK_SFX:  begin has_byte = 1'b1; byte_d = mult_char(s_q.mult); end
            default: begin has_byte = 1'b0; byte_d = CH_SP; end
        endcase
    end

    assign out_valid = (s_q.st == ST_EMIT) && has_byte;
    assign out_byte  = byte_d;
    assign rec_ready = (s_q.st == ST_IDLE);
    assign done      = s_q.done;
    assign fire      = out_valid && out_ready;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (rec_valid) begin
                    s_d.done    = 1'b0;
                    s_d.last    = rec_last;
                    s_d.cls     = comp_cls_e'(rec_class);
                    s_d.mult    = rec_mult;
                    s_d.idx     = rec_index;
                    s_d.na      = rec_node_a;
                    s_d.nb      = rec_node_b;
                    s_d.nc      = rec_node_c;
                    s_d.val     = rec_value;
                    s_d.step    = '0;
                    s_d.num_act = 1'b0;
                    s_d.dig     = '0;
                    if (comp_cls_e'(rec_class) == CLS_SKIP) begin
                        s_d.done = rec_last;
                    end else begin
                        s_d.st = ST_EMIT;
                    end
                end
            end
            default: begin
                case (tok.kind)
                    TK_NUM: begin
                        if (fire) begin
                            if (cur_di == '0) begin
                                s_d.step    = s_q.step + 1'b1;
                                s_d.num_act = 1'b0;
                            end else begin
                                s_d.dig     = cur_di - 1'b1;
                                s_d.num_act = 1'b1;
                            end
                        end
                    end
                    TK_END: begin
                        s_d.st   = ST_IDLE;
                        s_d.done = s_q.last;
                    end
                    default: begin
                        if (fire) begin
                            s_d.step = s_q.step + 1'b1;
                        end
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/netfmt_checker.sv
module netfmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rec_valid,
    input logic       rec_ready,
    input logic [1:0] rec_class,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       done
);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))) else $error("stall hold"); // R8

    AST_NO_INTAKE_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !rec_ready) else $error("intake while sending"); // R9

    AST_LF_FOLLOWS_CR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_byte == 8'h0D) |=> (out_valid && out_byte == 8'h0A)) else $error("line end"); // R5

    AST_BYTE_CHARSET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_byte == 8'h0D || out_byte == 8'h0A ||
                       (out_byte >= 8'h20 && out_byte <= 8'h7E))) else $error("charset"); // R5

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready && rec_class == 2'd3) |=> (rec_ready && !out_valid)) else $error("skip"); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid) else $error("done while sending"); // R10

endmodule

bind netlist_line_fmt netfmt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_class (rec_class),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .done      (done)
);

// File: tb/netlist_line_fmt_tb_top.sv
module netlist_line_fmt_tb_top;

    localparam int NW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rec_valid = 1'b0;
    logic          rec_ready;
    logic          rec_last = 1'b0;
    logic [1:0]    rec_class = 2'd0;
    logic [NW-1:0] rec_index = '0;
    logic [NW-1:0] rec_node_a = '0;
    logic [NW-1:0] rec_node_b = '0;
    logic [NW-1:0] rec_node_c = '0;
    logic [NW-1:0] rec_value = '0;
    logic [1:0]    rec_mult = 2'd0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_byte;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    netlist_line_fmt #(.NUM_W(NW), .DIGITS(3)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_last(rec_last),
        .rec_class(rec_class), .rec_index(rec_index),
        .rec_node_a(rec_node_a), .rec_node_b(rec_node_b), .rec_node_c(rec_node_c),
        .rec_value(rec_value), .rec_mult(rec_mult),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .done(done)
    );

    task automatic chk(bit ok, string req, string what, string act, string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%s expected=%s", req, what, act, exp);
        end
    endtask

    function automatic string eol();
        return $sformatf("%c%c", 8'd13, 8'd10);
    endfunction

    function automatic string sfx(int m);
        case (m)
            1: return "k";
            2: return "m";
            3: return "u";
            default: return "";
        endcase
    endfunction

    task automatic send_rec(int cls, int idx, int a, int b, int c, int val, int m, bit last);
        @(negedge clk);
        rec_class  = 2'(cls);
        rec_index  = NW'(idx);
        rec_node_a = NW'(a);
        rec_node_b = NW'(b);
        rec_node_c = NW'(c);
        rec_value  = NW'(val);
        rec_mult   = 2'(m);
        rec_last   = last;
        rec_valid  = 1'b1;
        while (!rec_ready) @(negedge clk);
        @(posedge clk);
        #1 rec_valid = 1'b0;
    endtask

    // mode 0: ready always high, 1: low every third cycle, 2: high every fourth cycle
    task automatic run_line(int cls, int idx, int a, int b, int c, int val, int m,
                            bit last, int mode, string exp, string req);
        string got = "";
        int cyc = 0;
        int gaps = 0;
        int holds = 0;
        int extra = 0;
        bit started = 0;
        bit busy_seen = 0;
        bit stall_prev = 0;
        bit hold_bad = 0;
        logic [7:0] prev = 8'h00;
        bit rdy;
        send_rec(cls, idx, a, b, c, val, m, last);
        while (got.len() < exp.len() && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1)
                chk(done == 1'b0, "R10", "done cleared on intake", $sformatf("%0b", done), "0");
            case (mode)
                1:       rdy = (cyc % 3 != 0);
                2:       rdy = (cyc % 4 == 0);
                default: rdy = 1'b1;
            endcase
            out_ready = rdy;
            if (stall_prev) begin
                holds++;
                if (!(out_valid && out_byte == prev)) hold_bad = 1;
            end
            stall_prev = out_valid && !rdy;
            prev = out_byte;
            if (out_valid) begin
                started = 1;
                if (!busy_seen) begin
                    busy_seen = 1;
                    chk(rec_ready == 1'b0, "R9", "rec_ready while sending",
                        $sformatf("%0b", rec_ready), "0");
                end
            end else if (started) begin
                gaps++;
            end
            if (out_valid && rdy) got = $sformatf("%s%c", got, out_byte);
        end
        chk(got == exp, req, "line text", got, exp);
        if (mode == 0)
            chk(gaps == 0, "R8", "back-to-back bytes", $sformatf("%0d gaps", gaps), "0 gaps");
        else
            chk(holds > 0 && !hold_bad, "R8", "byte held under stall",
                $sformatf("holds=%0d bad=%0b", holds, hold_bad), "holds>0 bad=0");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) extra++;
        end
        chk(extra == 0, "R5", "no bytes past line end", $sformatf("%0d", extra), "0");
        chk(rec_ready == 1'b1, "R9", "idle after line", $sformatf("%0b", rec_ready), "1");
        chk(done == last, "R10", "done after line", $sformatf("%0b", done), $sformatf("%0b", last));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rec_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
            $sformatf("%0b%0b%0b", rec_ready, out_valid, done), "100");
    endtask

    task automatic t_vsrc();
        run_line(0, 0, 0, 1, 0, 5, 0, 0, 0, {"V 0 0 1 DC 5", eol()}, "R2");
        run_line(0, 999, 100, 40, 0, 7, 2, 0, 2, {"V 999 100 40 DC 7", eol()}, "R2 R6");
    endtask

    task automatic t_resistor();
        run_line(1, 0, 1, 2, 0, 100, 1, 0, 0, {"R 0 1 2 100", sfx(1), eol()}, "R3");
        run_line(1, 12, 0, 999, 0, 0, 0, 0, 0, {"R 12 0 999 0", eol()}, "R3 R6");
        run_line(1, 3, 8, 9, 0, 47, 2, 0, 1, {"R 3 8 9 47", sfx(2), eol()}, "R3");
        run_line(1, 4, 10, 11, 0, 220, 3, 0, 0, {"R 4 10 11 220", sfx(3), eol()}, "R3");
    endtask

    task automatic t_npn();
        run_line(2, 0, 2, 3, 3, 0, 0, 0, 0, {"Q 0 2 3 3 NPN", eol()}, "R4");
        run_line(2, 7, 10, 20, 305, 0, 0, 0, 1, {"Q 7 10 20 305 NPN", eol()}, "R4 R6");
    endtask

    task automatic t_skip();
        int seen = 0;
        send_rec(3, 5, 1, 2, 3, 4, 1, 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) seen++;
        end
        chk(seen == 0, "R7", "skipped record is silent", $sformatf("%0d bytes", seen), "0 bytes");
        chk(rec_ready == 1'b1 && done == 1'b0, "R7", "ready after skip",
            $sformatf("%0b%0b", rec_ready, done), "10");
        run_line(1, 1, 2, 3, 0, 9, 0, 0, 0, {"R 1 2 3 9", eol()}, "R7");
    endtask

    task automatic t_done();
        run_line(0, 2, 5, 6, 0, 12, 0, 1, 0, {"V 2 5 6 DC 12", eol()}, "R10");
        send_rec(3, 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk(done == 1'b1 && out_valid == 1'b0, "R10", "done on skipped last record",
            $sformatf("%0b%0b", done, out_valid), "10");
        run_line(2, 1, 4, 5, 6, 0, 0, 1, 0, {"Q 1 4 5 6 NPN", eol()}, "R10");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_vsrc();
        t_resistor();
        t_npn();
        t_skip();
        t_done();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule